// File: doc/BRIEF.md
# Edge-Triggered Key Wakeup Port

This block is an 8-bit general-purpose I/O port. Every pin can also raise an interrupt when it sees an edge, so a row of keys or switches can wake the system. A small register bus reaches all of the port's state. The bus has an address, write data and a write enable, and its read data is combinational. Each pin has a direction bit. Output pins drive the value held in the data register. Input pins are sampled through a two-flop synchronizer.

Each pin has a polarity bit that sets two things: the kind of pull device requested and the edge that counts as active. A pin set as an input that sees its active edge sets its own flag bit. Software clears a flag by writing a 1 to it. Every flag that is also enabled feeds one shared interrupt request. The pull-enable and pull-select bits leave the block as control outputs for the pad ring.

To arm the wakeup, software does these steps in order:
1. Set the pins as inputs.
2. Choose the edges.
3. Write all ones to the flag register to clear stale flags.
4. Set the interrupt enables.

Top module: `kwu_port`

## Requirements
- R1: Register map: 0 holds the output value, 1 the direction, 2 the pin readback, 3 the pull enable, 4 the polarity, 5 the interrupt enable and 6 the flags. A direction bit of 1 makes that pin an output. `pad_oe` follows the direction register, and `pad_out` follows the output value register.
- R2: Reading address 0 returns the stored output value on bits whose direction is 1. On bits whose direction is 0 it returns the synchronized pin level.
- R3: Address 2 always returns the synchronized pin levels, whatever the direction. A change on `pin_raw` becomes visible after the second rising clock edge.
- R4: `pull_en` and `pull_sel` show the pull-enable and polarity registers. They change only when those registers are written.
- R5: A polarity bit of 0 makes a falling edge the active edge. A polarity bit of 1 makes a rising edge the active edge. The flag is set on the third rising clock edge after the pin changes. An edge of the other direction leaves the flag unchanged.
- R6: Writing 1 to a flag bit clears it. Writing 0 to a flag bit leaves it unchanged.
- R7: `irq` is high exactly when some bit has both its flag and its interrupt enable set.
- R8: After reset all registers read 0x00, every pin is an input, and `irq` is low.
- R9: If an active edge and a clearing write reach the same flag bit in the same cycle, the flag ends up set.
- R10: A pin whose direction is 1 never sets its flag. A flag is set even when its interrupt enable is 0.
- R11: Address 7 reads 0. Writes to address 2 or address 7 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write enable |
| bus_rdata | output | 8 | Read data (combinational) |
| pin_raw | input | 8 | Asynchronous pin levels from the pads |
| pad_oe | output | 8 | Output enable for each pin |
| pad_out | output | 8 | Output value for each pin |
| pull_en | output | 8 | Pull device enable for each pin |
| pull_sel | output | 8 | Pull select for each pin (0 = up, 1 = down) |
| irq | output | 1 | Shared interrupt request |

## Verification
A detected pin edge and a software write-1-to-clear can land on the same flag bit in the same clock cycle. The bench provokes this by lowering a pin and then counting negative edges. It launches the clearing write so that the write commits on the same rising clock edge that the edge detector reports. The flag must read back as set afterwards. A clear issued on a later cycle is checked separately and must leave the flag clear.

// File: rtl/kwu_port.sv
module kwu_port #(
  parameter int WIDTH = 8,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  input  logic             bus_we,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] pin_raw,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pull_en,
  output logic [WIDTH-1:0] pull_sel,
  output logic             irq
);
  localparam logic [AW-1:0] A_OUT  = AW'(0);
  localparam logic [AW-1:0] A_DIR  = AW'(1);
  localparam logic [AW-1:0] A_PIN  = AW'(2);
  localparam logic [AW-1:0] A_PULL = AW'(3);
  localparam logic [AW-1:0] A_POL  = AW'(4);
  localparam logic [AW-1:0] A_IEN  = AW'(5);
  localparam logic [AW-1:0] A_FLAG = AW'(6);

  logic [WIDTH-1:0] out_q, dir_q, pull_q, pol_q, ien_q, flag_q;
  logic [WIDTH-1:0] sync1_q, sync2_q, prev_q;
  logic [WIDTH-1:0] rise, fall, edge_hit, clr;

  assign rise     = sync2_q & ~prev_q;
  assign fall     = ~sync2_q & prev_q;
  assign edge_hit = ~dir_q & ((pol_q & rise) | (~pol_q & fall));
  assign clr      = (bus_we && bus_addr == A_FLAG) ? bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
      flag_q  <= '0;
    end else begin
      sync1_q <= pin_raw;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      flag_q  <= (flag_q & ~clr) | edge_hit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '0;
      pull_q <= '0;
      pol_q  <= '0;
      ien_q  <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        A_OUT:   out_q  <= bus_wdata;
        A_DIR:   dir_q  <= bus_wdata;
        A_PULL:  pull_q <= bus_wdata;
        A_POL:   pol_q  <= bus_wdata;
        A_IEN:   ien_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      A_OUT:   bus_rdata = (out_q & dir_q) | (sync2_q & ~dir_q);
      A_DIR:   bus_rdata = dir_q;
      A_PIN:   bus_rdata = sync2_q;
      A_PULL:  bus_rdata = pull_q;
      A_POL:   bus_rdata = pol_q;
      A_IEN:   bus_rdata = ien_q;
      A_FLAG:  bus_rdata = flag_q;
      default: bus_rdata = '0;
    endcase
  end

  assign pad_oe   = dir_q;
  assign pad_out  = out_q;
  assign pull_en  = pull_q;
  assign pull_sel = pol_q;
  assign irq      = |(flag_q & ien_q);
endmodule

// File: rtl/kwu_port_chk.sv
module kwu_port_chk #(
  parameter int WIDTH = 8,
  parameter int AW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    bus_addr,
  input logic [WIDTH-1:0] bus_wdata,
  input logic             bus_we,
  input logic [WIDTH-1:0] pad_oe,
  input logic [WIDTH-1:0] pull_en,
  input logic             irq,
  input logic [WIDTH-1:0] ien_q,
  input logic [WIDTH-1:0] flag_q,
  input logic [WIDTH-1:0] dir_q,
  input logic [WIDTH-1:0] edge_hit
);
  localparam logic [AW-1:0] A_DIR  = AW'(1);
  localparam logic [AW-1:0] A_PULL = AW'(3);

  // R1
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_DIR) |=> pad_oe == $past(bus_wdata));

  // R4
  pull_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == A_PULL) |=> $stable(pull_en));

  // R5
  flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(edge_hit)) == '0));

  // R10
  out_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & ~$past(flag_q) & $past(dir_q)) == '0));

  // R9
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(edge_hit) & ~flag_q) == '0));

  // R7
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ien_q == '0) || (flag_q == '0)) |-> !irq);
endmodule

bind kwu_port kwu_port_chk #(.WIDTH(WIDTH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .pad_oe(pad_oe), .pull_en(pull_en), .irq(irq),
  .ien_q(ien_q), .flag_q(flag_q), .dir_q(dir_q), .edge_hit(edge_hit)
);

// File: tb/kwu_port_tb.sv
`timescale 1ns/1ps
module kwu_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_rdata, pin_raw, pad_oe, pad_out, pull_en, pull_sel;
  logic       irq;
  int checks = 0;
  int failures = 0;
  logic [7:0] v;

  always #4 clk = ~clk;

  kwu_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pin_raw(pin_raw),
    .pad_oe(pad_oe), .pad_out(pad_out), .pull_en(pull_en),
    .pull_sel(pull_sel), .irq(irq)
  );

  // {addr, write data, expected read of same addr}; pins held at 0x00
  localparam logic [18:0] VEC [8] = '{
    {3'd1, 8'hA5, 8'hA5},   // R1 direction
    {3'd0, 8'h3C, 8'h24},   // R2 mix of output and input bits
    {3'd3, 8'h0F, 8'h0F},   // R4 pull enable
    {3'd4, 8'hF0, 8'hF0},   // R4 polarity
    {3'd5, 8'h81, 8'h81},   // R7 enable
    {3'd2, 8'h55, 8'h00},   // R11 readback not writable
    {3'd7, 8'hFF, 8'h00},   // R11 unmapped
    {3'd6, 8'hFF, 8'h00}    // R6 clearing with nothing pending
  };

  task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    pin_raw = 8'h00;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], v);
      check(v, 8'h00, "R8 reset register value");
    end
    check({7'd0, irq}, 8'h00, "R8 irq after reset");
    check(pad_oe, 8'h00, "R8 pins start as inputs");

    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][18:16], VEC[i][15:8]);
      rd(VEC[i][18:16], v);
      check(v, VEC[i][7:0], "R1/R2/R4/R6/R7/R11 table");
    end
    check(pad_oe, 8'hA5, "R1 pad_oe");
    check(pad_out, 8'h3C, "R1 pad_out");
    check(pull_en, 8'h0F, "R4 pull_en");
    check(pull_sel, 8'hF0, "R4 pull_sel");

    // R3 latency and direction independence
    wr(3'd1, 8'h00);
    pin_raw = 8'h5A;
    wait_cyc(1);
    rd(3'd2, v); check(v, 8'h00, "R3 one edge not yet visible");
    wait_cyc(1);
    rd(3'd2, v); check(v, 8'h5A, "R3 visible after two edges");
    rd(3'd0, v); check(v, 8'h5A, "R2 input pins read pin level");
    wr(3'd1, 8'hFF);
    wr(3'd0, 8'h00);
    rd(3'd2, v); check(v, 8'h5A, "R3 readback with outputs");
    rd(3'd0, v); check(v, 8'h00, "R2 output pins read stored value");

    // R5 falling edge, R10 flag without enable, R7 irq
    wr(3'd5, 8'h00);
    wr(3'd4, 8'h00);
    wr(3'd1, 8'h00);
    pin_raw = 8'hFF;
    wait_cyc(4);
    wr(3'd6, 8'hFF);
    rd(3'd6, v); check(v, 8'h00, "R6 stale flags cleared");
    pin_raw = 8'hFE;
    wait_cyc(3);
    rd(3'd6, v); check(v, 8'h01, "R5 falling edge flagged, R10 with enable off");
    check({7'd0, irq}, 8'h00, "R7 irq low without enable");
    wr(3'd5, 8'h01);
    check({7'd0, irq}, 8'h01, "R7 irq high when enabled");
    wr(3'd5, 8'h80);
    check({7'd0, irq}, 8'h00, "R7 irq low, other bit enabled");
    wr(3'd6, 8'h00);
    rd(3'd6, v); check(v, 8'h01, "R6 write zero keeps flag");
    wr(3'd6, 8'h01);
    rd(3'd6, v); check(v, 8'h00, "R6 write one clears flag");

    // R5 rising polarity
    wr(3'd4, 8'h02);
    pin_raw = 8'hFC;
    wait_cyc(3);
    rd(3'd6, v); check(v, 8'h00, "R5 falling ignored with polarity 1");
    pin_raw = 8'hFE;
    wait_cyc(3);
    rd(3'd6, v); check(v, 8'h02, "R5 rising edge flagged");

    // R10 output pin never flags
    wr(3'd6, 8'hFF);
    wr(3'd4, 8'h00);
    wr(3'd1, 8'h04);
    pin_raw = 8'hFA;
    wait_cyc(3);
    rd(3'd6, v); check(v, 8'h00, "R10 output pin edge ignored");
    wr(3'd1, 8'h00);
    wait_cyc(2);

    // R9 edge and clear in the same cycle
    pin_raw = 8'hF2;
    wait_cyc(2);
    bus_addr = 3'd6; bus_wdata = 8'h08; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    rd(3'd6, v); check(v, 8'h08, "R9 edge wins over clear");
    wr(3'd6, 8'h08);
    rd(3'd6, v); check(v, 8'h00, "R9 later clear takes effect");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule